// File: doc/BRIEF.md
# Redundant-Digit to Sign/Magnitude Converter

This block turns a word of radix-2 signed digits, each digit carried on two wires, into an ordinary signed-magnitude binary number. It also reports whether the value is negative and whether it is zero. It sits in the pipeline stage that follows a carry-free adder. That adder leaves its sum in redundant form, and this stage resolves the sum before it is stored or forwarded.

The digit word is split into a word of positive-digit positions and a word of negative-digit positions. The value of the input is the first word minus the second. Both differences, positive-minus-negative and negative-minus-positive, are formed side by side by two parallel-prefix borrow networks whose depth grows as log2 of the digit count. The borrow out of each network gives the sign and the zero flag at once. The magnitude is taken from whichever difference is non-negative. One register stage holds the result, so the latency is one clock.

Top module: `sd2sm_xlate`

## Requirements
- R1: Digit i occupies bits [2i+1:2i] of `in_digits`. Code 2'b01 means +1, code 2'b10 means -1, and code 2'b00 means 0. The unused code 2'b11 is taken as 0.
- R2: For an accepted word, `out_mag` equals the absolute value of the sum over i of digit_i times 2^i, as a DIGITS-bit unsigned number.
- R3: `out_neg` is 1 exactly when that value is below zero, which is the case when the most significant nonzero digit is -1.
- R4: `out_zero` is 1 exactly when every digit is 0. A zero result is always given with `out_neg` = 0 and `out_mag` = 0.
- R5: `out_valid` is `in_valid` delayed by one clock. The result fields change only in the cycle after `in_valid` is 1, and they hold their values otherwise.
- R6: While `rst_n` is low, and right after it goes high, `out_valid` = 0, `out_mag` = 0, `out_neg` = 0 and `out_zero` = 1.
- R7: The extremes convert exactly. If all digits are -1, the result is `out_mag` = 2^DIGITS-1 with `out_neg` = 1. If all digits are +1, the result is the same magnitude with `out_neg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The digit word on `in_digits` is to be converted |
| in_digits | input | 2*DIGITS | Encoded signed-digit word, two bits per digit |
| out_valid | output | 1 | Result fields belong to the word accepted last cycle |
| out_mag | output | DIGITS | Magnitude of the converted value |
| out_neg | output | 1 | Sign of the converted value, 1 for negative |
| out_zero | output | 1 | The converted value is zero |

## Verification
A fault in the borrow network appears as a wrong magnitude one clock after the word is accepted. It is most likely to show on words whose borrows run across many positions, such as a single +1 at the top over a -1 at the bottom. A wrong sign choice shows in that same cycle in two ways: `out_neg` disagrees with the top nonzero digit, and the magnitude becomes the two's-complement image of the correct one. A stale or leaking result register shows in the idle cycles that follow, when the outputs must stay frozen.

// File: rtl/sd2sm_pkg.sv
package sd2sm_pkg;

    typedef enum logic [1:0] {
        SD_ZERO = 2'b00,
        SD_POS  = 2'b01,
        SD_NEG  = 2'b10,
        SD_RSVD = 2'b11
    } sd_code_e;

endpackage

// File: rtl/sd2sm_split.sv
module sd2sm_split #(
    parameter int DIGITS = 64
) (
    input  logic [2*DIGITS-1:0] digits,
    output logic [DIGITS-1:0]   pos_word,
    output logic [DIGITS-1:0]   neg_word
);
    import sd2sm_pkg::*;

    // R1: per-digit decode; the reserved code counts as zero
    always_comb begin
        pos_word = '0;
        neg_word = '0;
        for (int i = 0; i < DIGITS; i++) begin
            unique case (sd_code_e'(digits[2*i +: 2]))
                SD_POS:  pos_word[i] = 1'b1;
                SD_NEG:  neg_word[i] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sd2sm_prefix_sub.sv
module sd2sm_prefix_sub #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] minuend,
    input  logic [WIDTH-1:0] subtrahend,
    output logic [WIDTH-1:0] diff,
    output logic             borrow_out
);
    localparam int LEVELS = $clog2(WIDTH);

    // generate: bit needs a borrow; propagate: bit passes a borrow through
    logic [WIDTH-1:0] gen_lv  [0:LEVELS];
    logic [WIDTH-1:0] prop_lv [0:LEVELS];
    logic [WIDTH-1:0] borrow_in;

    assign gen_lv[0]  = ~minuend & subtrahend;
    assign prop_lv[0] = ~(minuend ^ subtrahend);

    // Log-depth prefix combine, span doubles each level
    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i >= SPAN) begin : g_merge
                assign gen_lv[l+1][i]  = gen_lv[l][i] | (prop_lv[l][i] & gen_lv[l][i-SPAN]);
                assign prop_lv[l+1][i] = prop_lv[l][i] & prop_lv[l][i-SPAN];
            end else begin : g_pass
                assign gen_lv[l+1][i]  = gen_lv[l][i];
                assign prop_lv[l+1][i] = prop_lv[l][i];
            end
        end
    end

    assign borrow_in  = {gen_lv[LEVELS][WIDTH-2:0], 1'b0};
    assign diff       = minuend ^ subtrahend ^ borrow_in;
    assign borrow_out = gen_lv[LEVELS][WIDTH-1];

endmodule

// File: rtl/sd2sm_xlate.sv
module sd2sm_xlate #(
    parameter int DIGITS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*DIGITS-1:0] in_digits,
    output logic                out_valid,
    output logic [DIGITS-1:0]   out_mag,
    output logic                out_neg,
    output logic                out_zero
);
    typedef struct packed {
        logic              vld;
        logic [DIGITS-1:0] mag;
        logic              neg;
        logic              zero;
    } res_t;

    localparam res_t RES_RESET = '{vld: 1'b0, mag: '0, neg: 1'b0, zero: 1'b1};

    logic [DIGITS-1:0] pos_word, neg_word;
    logic [DIGITS-1:0] diff_pn, diff_np;
    logic              brw_pn, brw_np;
    res_t              res_d, res_q;

    sd2sm_split #(.DIGITS(DIGITS)) u_split (
        .digits   (in_digits),
        .pos_word (pos_word),
        .neg_word (neg_word)
    );

    sd2sm_prefix_sub #(.WIDTH(DIGITS)) u_sub_pn (
        .minuend    (pos_word),
        .subtrahend (neg_word),
        .diff       (diff_pn),
        .borrow_out (brw_pn)
    );

    sd2sm_prefix_sub #(.WIDTH(DIGITS)) u_sub_np (
        .minuend    (neg_word),
        .subtrahend (pos_word),
        .diff       (diff_np),
        .borrow_out (brw_np)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            // borrow out of P-N marks a negative value; no borrow either way means equal
            res_d.neg  = brw_pn;
            res_d.zero = ~brw_pn & ~brw_np;
            res_d.mag  = brw_pn ? diff_np : diff_pn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= RES_RESET;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_mag   = res_q.mag;
    assign out_neg   = res_q.neg;
    assign out_zero  = res_q.zero;

endmodule

// File: rtl/sd2sm_xlate_chk.sv
module sd2sm_xlate_chk #(
    parameter int DIGITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2*DIGITS-1:0] in_digits,
    input logic                out_valid,
    input logic [DIGITS-1:0]   out_mag,
    input logic                out_neg,
    input logic                out_zero
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mag) && $stable(out_neg) && $stable(out_zero))); // R5

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (!out_neg && out_mag == '0)); // R4

    AST_NONZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero) |-> (out_mag != '0)); // R2

    AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_digits == '0) |=> out_zero); // R4

    AST_TOP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_digits[2*DIGITS-1 -: 2] == 2'b10) |=> out_neg); // R3

    AST_TOP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_digits[2*DIGITS-1 -: 2] == 2'b01) |=> (!out_neg && !out_zero)); // R3

endmodule

bind sd2sm_xlate sd2sm_xlate_chk #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_digits (in_digits),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_neg   (out_neg),
    .out_zero  (out_zero)
);

// File: tb/sd2sm_xlate_bench.sv
module sd2sm_xlate_bench;
    localparam int D = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [2*D-1:0] in_digits = '0;
    logic           out_valid;
    logic [D-1:0]   out_mag;
    logic           out_neg;
    logic           out_zero;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sd2sm_xlate #(.DIGITS(D)) u_sd2sm_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_digits (in_digits),
        .out_valid (out_valid),
        .out_mag   (out_mag),
        .out_neg   (out_neg),
        .out_zero  (out_zero)
    );

    // {stimulus[31:0], neg, zero, mag[15:0]}
    localparam int NVEC = 10;
    localparam logic [49:0] VEC [0:NVEC-1] = '{
        {32'h0000_0000, 1'b0, 1'b1, 16'h0000}, // R4 all zero
        {32'h0000_0001, 1'b0, 1'b0, 16'h0001}, // R2 single +1
        {32'h0000_0002, 1'b1, 1'b0, 16'h0001}, // R3 single -1
        {32'h4000_0002, 1'b0, 1'b0, 16'h7FFF}, // R3 +1 top, -1 bottom
        {32'h8000_0001, 1'b1, 1'b0, 16'h7FFF}, // R3 -1 top, +1 bottom
        {32'h5555_5555, 1'b0, 1'b0, 16'hFFFF}, // R7 all +1
        {32'hAAAA_AAAA, 1'b1, 1'b0, 16'hFFFF}, // R7 all -1
        {32'h0000_4909, 1'b0, 1'b0, 16'h006F}, // R2 mixed digits, 145-34
        {32'hFFFF_FFFF, 1'b0, 1'b1, 16'h0000}, // R1 reserved code as zero
        {32'h0000_0006, 1'b0, 1'b0, 16'h0001}  // R2 +2-1
    };

    task automatic ref_model(input logic [2*D-1:0] dg, output logic [D-1:0] mag,
                             output logic neg, output logic zero);
        logic [D-1:0] p = '0;
        logic [D-1:0] n = '0;
        for (int i = 0; i < D; i++) begin
            if (dg[2*i +: 2] == 2'b01) p[i] = 1'b1;
            if (dg[2*i +: 2] == 2'b10) n[i] = 1'b1;
        end
        neg  = (n > p);
        mag  = neg ? (n - p) : (p - n);
        zero = (p == n);
    endtask

    task automatic check_out(input string req, input logic vld, input logic [D-1:0] mag,
                             input logic neg, input logic zero);
        checks++;
        if (out_valid !== vld || out_mag !== mag || out_neg !== neg || out_zero !== zero) begin
            errors++;
            $display("FAIL %s: got vld=%b mag=%h neg=%b zero=%b, expected vld=%b mag=%h neg=%b zero=%b",
                     req, out_valid, out_mag, out_neg, out_zero, vld, mag, neg, zero);
        end
    endtask

    // drive one word, then sample one negedge after the capturing edge
    task automatic apply(input logic [2*D-1:0] dg);
        @(negedge clk);
        in_valid  = 1'b1;
        in_digits = dg;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [D-1:0] emag;
        logic         eneg, ezero;

        repeat (3) @(negedge clk);
        check_out("R6 in reset", 1'b0, '0, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R6 after reset", 1'b0, '0, 1'b0, 1'b1);

        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k][49:18]);
            check_out("R1/R2/R3/R4/R7 table", 1'b1, VEC[k][15:0], VEC[k][17], VEC[k][16]);
        end

        // R5: idle with new digits, result must hold and valid drop
        apply(32'h8000_0001);
        @(negedge clk);
        in_digits = 32'h0000_0001;
        @(negedge clk);
        check_out("R5 hold while idle", 1'b0, 16'h7FFF, 1'b1, 1'b0);

        // R5: back-to-back words each land one cycle later
        @(negedge clk);
        in_valid  = 1'b1;
        in_digits = 32'h0000_0001;
        @(negedge clk);
        check_out("R5 first of pair", 1'b1, 16'h0001, 1'b0, 1'b0);
        in_digits = 32'hAAAA_AAAA;
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R5 second of pair", 1'b1, 16'hFFFF, 1'b1, 1'b0);

        // R2/R3/R4 random words against the integer model
        for (int k = 0; k < 300; k++) begin
            logic [2*D-1:0] dg;
            dg = $urandom;
            if (k % 7 == 0) dg = dg & 32'h5555_5555;
            if (k % 11 == 0) dg = dg & 32'hAAAA_AAAA;
            apply(dg);
            ref_model(dg, emag, eneg, ezero);
            check_out("R2/R3/R4 random", 1'b1, emag, eneg, ezero);
        end

        // R6: reset mid-run clears a held negative result
        apply(32'hAAAA_AAAA);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R6 mid-run reset", 1'b0, '0, 1'b0, 1'b1);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule